// File: doc/BRIEF.md
# Sequencer Flow-Control and Return-Address Stack

This block is the flow-control unit of an autonomous bus-message sequencer. An instruction fetcher hands it one decoded flow instruction at a time. Each instruction carries an opcode (continue, jump, call or return), a condition selector, the address of the current instruction, its length and a target address. The unit captures the current error flags, status-word bits and external input when it accepts the request. It evaluates the selected condition against that snapshot and returns the address to fetch next. Return addresses are saved in a reserved region of 256 words at the very top of a 16-bit-addressed word memory, through a simple synchronous RAM port. The region holds at most 255 saved addresses.

The control is a single state machine. Its states are IDLE, EVAL, PUSH, POP, POP_WAIT, DONE and HALT. Its transitions are:
- IDLE→EVAL when a request is accepted.
- EVAL→DONE when no stack access is needed.
- EVAL→PUSH when a taken call still has room.
- EVAL→POP when a taken return finds a saved address.
- EVAL→HALT on an illegal opcode, an overflow or an underflow.
- PUSH→DONE.
- POP→POP_WAIT, and POP_WAIT→DONE.
- DONE→IDLE.
- HALT→HALT, which only reset leaves.

Once a fault has stopped the unit, it stays stopped and ignores all work until reset.

Top module: `seq_flow_stack`

## Requirements
- R1: After reset, `busy`, `done`, `halted`, `stack_fault` and `opcode_fault` are 0 and `depth` is 0.
- R2: Some instructions leave the stack alone: a continue (opcode 0, whatever its condition), or a jump, call or return whose condition is false. Such an instruction produces `next_pc` = `cur_pc` + `ins_len` (modulo 2^16), makes no memory access and leaves `depth` unchanged.
- R3: `cond_sel[3:0]` picks the condition source. Index 0 is always true. Indexes 1 to 4 are `err_flags[0..3]`, indexes 5 to 12 are `sw_flags[0..7]` and index 13 is `ext_flag`. Indexes 14 and 15 read as false. `cond_sel[4]` inverts the picked value. The flags are sampled in the cycle the request is accepted.
- R4: A jump (opcode 1) with a true condition produces `next_pc` = `target`.
- R5: A call (opcode 2) with a true condition does three things. It writes `cur_pc` + `ins_len` to address 0xFFFF − `depth`, which is always inside 0xFF00..0xFFFF. It then increments `depth`. It produces `next_pc` = `target`.
- R6: A return (opcode 3) with a true condition reads address 0xFFFF − `depth` + 1. It decrements `depth` and produces the word read as `next_pc`. Saved addresses therefore come back in last-in, first-out order.
- R7: A taken call while `depth` = 255 writes nothing. It leaves `depth` at 255 and enters HALT with `stack_fault` = 1.
- R8: A taken return while `depth` = 0 reads nothing. It enters HALT with `stack_fault` = 1.
- R9: Opcodes 4 to 7 enter HALT with `opcode_fault` = 1 and `stack_fault` = 0, whatever the condition.
- R10: In HALT, requests are ignored: there is no `done`, no memory access and no change of `depth` until reset.
- R11: `done` is a one-cycle pulse. Counting clock edges from the one that accepts `req`, it appears after 2 edges for continue and jump, 3 for call and 4 for return. `req` is only accepted in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Flow instruction valid (accepted in IDLE) |
| opcode | input | 3 | 0 continue, 1 jump, 2 call, 3 return, others illegal |
| cond_sel | input | 5 | [4] invert, [3:0] condition source index |
| cur_pc | input | 16 | Address of the current instruction |
| ins_len | input | 4 | Length of the current instruction in words |
| target | input | 16 | Jump or call destination |
| err_flags | input | 4 | Error condition flags |
| sw_flags | input | 8 | Status-word bits of the last message |
| ext_flag | input | 1 | External condition input |
| busy | output | 1 | An accepted instruction is in progress |
| done | output | 1 | `next_pc` is valid (one-cycle pulse) |
| next_pc | output | 16 | Address to fetch next |
| depth | output | 8 | Number of saved return addresses |
| halted | output | 1 | Unit stopped by a fault |
| stack_fault | output | 1 | Stop caused by overflow or underflow |
| opcode_fault | output | 1 | Stop caused by an illegal opcode |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid the cycle after a read strobe |

## Verification
The bench fills the stack to exactly 255 entries and then issues one more taken call. An off-by-one full test would either write the 256th word of the region or stop one call too early. It returns on an empty stack and expects a halt; a pointer that wrapped would instead read 0x0000 and hand back a stale address. Nested calls followed by returns check last-in, first-out order and the exact addresses used. A design that pre-decrements instead of post-decrements would read one slot away from the slot it wrote. Condition tests cover the inverted, out-of-range and external sources, and a false call or return must leave the memory port silent. Issuing work after a halt checks that the stop really sticks.

// File: rtl/seq_stk_pkg.sv
package seq_stk_pkg;

    localparam int OP_W = 3;

    localparam logic [OP_W-1:0] OP_CONT = 3'd0;
    localparam logic [OP_W-1:0] OP_JUMP = 3'd1;
    localparam logic [OP_W-1:0] OP_CALL = 3'd2;
    localparam logic [OP_W-1:0] OP_RET  = 3'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_PUSH,
        ST_POP,
        ST_POP_WAIT,
        ST_DONE,
        ST_HALT
    } seq_state_e;

    function automatic logic op_is_legal(input logic [OP_W-1:0] op);
        return (op <= OP_RET);
    endfunction

endpackage

// File: rtl/seq_cond_eval.sv
module seq_cond_eval #(
    parameter int ERR_W = 4,
    parameter int SW_W  = 8,
    parameter int IDX_W = 4
) (
    input  logic [IDX_W:0]   sel,
    input  logic [ERR_W-1:0] err,
    input  logic [SW_W-1:0]  sw,
    input  logic             ext,
    output logic             hit
);
    localparam int N_SRC = ERR_W + SW_W + 2;

    logic [N_SRC-1:0] src;
    logic             raw;

    assign src = {ext, sw, err, 1'b1};

    always_comb begin
        raw = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (sel[IDX_W-1:0] == IDX_W'(i)) begin
                raw = src[i];
            end
        end
        hit = raw ^ sel[IDX_W];
    end

endmodule

// File: rtl/seq_stk_ptr.sv
module seq_stk_ptr #(
    parameter int ADDR_W    = 16,
    parameter int STK_WORDS = 256,
    parameter int DEPTH_W   = $clog2(STK_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic               pop,
    output logic [DEPTH_W-1:0] depth,
    output logic               full,
    output logic               empty,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [ADDR_W-1:0]  rd_addr
);
    localparam int              MAX_ENTRIES = STK_WORDS - 1;
    localparam logic [ADDR_W-1:0] TOP_ADDR  = {ADDR_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth <= '0;
        end else if (push && !full) begin
            depth <= depth + DEPTH_W'(1);
        end else if (pop && !empty) begin
            depth <= depth - DEPTH_W'(1);
        end
    end

    assign full    = (depth == DEPTH_W'(MAX_ENTRIES));
    assign empty   = (depth == '0);
    assign wr_addr = TOP_ADDR - ADDR_W'(depth);
    assign rd_addr = wr_addr + ADDR_W'(1);

endmodule

// File: rtl/seq_flow_stack.sv
module seq_flow_stack
    import seq_stk_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int LEN_W     = 4,
    parameter int ERR_W     = 4,
    parameter int SW_W      = 8,
    parameter int IDX_W     = 4,
    parameter int STK_WORDS = 256,
    parameter int DEPTH_W   = $clog2(STK_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [2:0]         opcode,
    input  logic [IDX_W:0]     cond_sel,
    input  logic [ADDR_W-1:0]  cur_pc,
    input  logic [LEN_W-1:0]   ins_len,
    input  logic [ADDR_W-1:0]  target,
    input  logic [ERR_W-1:0]   err_flags,
    input  logic [SW_W-1:0]    sw_flags,
    input  logic               ext_flag,
    output logic               busy,
    output logic               done,
    output logic [ADDR_W-1:0]  next_pc,
    output logic [DEPTH_W-1:0] depth,
    output logic               halted,
    output logic               stack_fault,
    output logic               opcode_fault,
    output logic               mem_en,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [ADDR_W-1:0]  mem_wdata,
    input  logic [ADDR_W-1:0]  mem_rdata
);
    seq_state_e state, state_nx;

    logic [OP_W-1:0]   op_q;
    logic [IDX_W:0]    sel_q;
    logic [ADDR_W-1:0] link_q;
    logic [ADDR_W-1:0] tgt_q;
    logic [ERR_W-1:0]  err_q;
    logic [SW_W-1:0]   sw_q;
    logic              ext_q;

    logic              cond_hit;
    logic              stk_full, stk_empty;
    logic [ADDR_W-1:0] stk_wr_addr, stk_rd_addr;
    logic              do_push, do_pop;

    logic              illegal_op;
    logic              want_push, want_pop;
    logic              stk_err;

    seq_cond_eval #(
        .ERR_W (ERR_W),
        .SW_W  (SW_W),
        .IDX_W (IDX_W)
    ) u_cond (
        .sel (sel_q),
        .err (err_q),
        .sw  (sw_q),
        .ext (ext_q),
        .hit (cond_hit)
    );

    seq_stk_ptr #(
        .ADDR_W    (ADDR_W),
        .STK_WORDS (STK_WORDS),
        .DEPTH_W   (DEPTH_W)
    ) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (do_push),
        .pop     (do_pop),
        .depth   (depth),
        .full    (stk_full),
        .empty   (stk_empty),
        .wr_addr (stk_wr_addr),
        .rd_addr (stk_rd_addr)
    );

    // Decode of the captured instruction
    always_comb begin
        illegal_op = !op_is_legal(op_q);
        want_push  = (op_q == OP_CALL) && cond_hit;
        want_pop   = (op_q == OP_RET)  && cond_hit;
        stk_err    = (want_push && stk_full) || (want_pop && stk_empty);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req) state_nx = ST_EVAL;
            end
            ST_EVAL: begin
                if (illegal_op || stk_err) state_nx = ST_HALT;
                else if (want_push)        state_nx = ST_PUSH;
                else if (want_pop)         state_nx = ST_POP;
                else                       state_nx = ST_DONE;
            end
            ST_PUSH:     state_nx = ST_DONE;
            ST_POP:      state_nx = ST_POP_WAIT;
            ST_POP_WAIT: state_nx = ST_DONE;
            ST_DONE:     state_nx = ST_IDLE;
            ST_HALT:     state_nx = ST_HALT;
            default:     state_nx = ST_HALT;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        busy      = 1'b0;
        done      = 1'b0;
        halted    = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = stk_rd_addr;
        mem_wdata = link_q;
        do_push   = 1'b0;
        do_pop    = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_EVAL: busy = 1'b1;
            ST_PUSH: begin
                busy     = 1'b1;
                mem_en   = 1'b1;
                mem_we   = 1'b1;
                mem_addr = stk_wr_addr;
                do_push  = 1'b1;
            end
            ST_POP: begin
                busy   = 1'b1;
                mem_en = 1'b1;
                do_pop = 1'b1;
            end
            ST_POP_WAIT: busy = 1'b1;
            ST_DONE: begin
                busy = 1'b1;
                done = 1'b1;
            end
            ST_HALT: halted = 1'b1;
            default: halted = 1'b1;
        endcase
    end

    // Request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_CONT;
            sel_q  <= '0;
            link_q <= '0;
            tgt_q  <= '0;
            err_q  <= '0;
            sw_q   <= '0;
            ext_q  <= 1'b0;
        end else if (state == ST_IDLE && req) begin
            op_q   <= opcode;
            sel_q  <= cond_sel;
            link_q <= cur_pc + ADDR_W'(ins_len);
            tgt_q  <= target;
            err_q  <= err_flags;
            sw_q   <= sw_flags;
            ext_q  <= ext_flag;
        end
    end

    // Next fetch address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_pc <= '0;
        end else begin
            unique case (state)
                ST_EVAL: begin
                    if (op_q == OP_JUMP && cond_hit) next_pc <= tgt_q;
                    else                             next_pc <= link_q;
                end
                ST_PUSH:     next_pc <= tgt_q;
                ST_POP_WAIT: next_pc <= mem_rdata;
                default:     next_pc <= next_pc;
            endcase
        end
    end

    // Sticky fault causes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stack_fault  <= 1'b0;
            opcode_fault <= 1'b0;
        end else if (state == ST_EVAL) begin
            if (illegal_op)   opcode_fault <= 1'b1;
            else if (stk_err) stack_fault  <= 1'b1;
        end
    end

endmodule

// File: rtl/seq_flow_stack_chk.sv
module seq_flow_stack_chk #(
    parameter int ADDR_W    = 16,
    parameter int STK_WORDS = 256,
    parameter int DEPTH_W   = $clog2(STK_WORDS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req,
    input logic               done,
    input logic               halted,
    input logic               stack_fault,
    input logic               opcode_fault,
    input logic [DEPTH_W-1:0] depth,
    input logic               mem_en,
    input logic               mem_we,
    input logic [ADDR_W-1:0]  mem_addr
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
    localparam logic [DEPTH_W-1:0] MAX_D   = DEPTH_W'(STK_WORDS - 1);

    a_r5_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |=> (depth == $past(depth) + DEPTH_W'(1)));

    a_r5_push_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> (mem_addr == TOP_ADDR - ADDR_W'(depth)));

    a_r6_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> (depth == $past(depth) - DEPTH_W'(1)));

    a_r6_pop_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |-> (mem_addr == TOP_ADDR - ADDR_W'(depth) + ADDR_W'(1)));

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (depth == MAX_D) |-> !(mem_en && mem_we));

    a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (depth == '0) |-> !(mem_en && !mem_we));

    a_r9_fault_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (stack_fault || opcode_fault) |-> halted);

    a_r10_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_en && !done));

    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(depth)));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind seq_flow_stack seq_flow_stack_chk #(
    .ADDR_W    (ADDR_W),
    .STK_WORDS (STK_WORDS),
    .DEPTH_W   (DEPTH_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req          (req),
    .done         (done),
    .halted       (halted),
    .stack_fault  (stack_fault),
    .opcode_fault (opcode_fault),
    .depth        (depth),
    .mem_en       (mem_en),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr)
);

// File: tb/seq_flow_stack_test.sv
module seq_flow_stack_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [2:0]  opcode = '0;
    logic [4:0]  cond_sel = '0;
    logic [15:0] cur_pc = '0;
    logic [3:0]  ins_len = '0;
    logic [15:0] target = '0;
    logic [3:0]  err_flags = '0;
    logic [7:0]  sw_flags = '0;
    logic        ext_flag = 1'b0;
    logic        busy, done, halted, stack_fault, opcode_fault;
    logic [15:0] next_pc;
    logic [7:0]  depth;
    logic        mem_en, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    seq_flow_stack uut (
        .clk (clk), .rst_n (rst_n), .req (req), .opcode (opcode),
        .cond_sel (cond_sel), .cur_pc (cur_pc), .ins_len (ins_len),
        .target (target), .err_flags (err_flags), .sw_flags (sw_flags),
        .ext_flag (ext_flag), .busy (busy), .done (done), .next_pc (next_pc),
        .depth (depth), .halted (halted), .stack_fault (stack_fault),
        .opcode_fault (opcode_fault), .mem_en (mem_en), .mem_we (mem_we),
        .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_rdata (mem_rdata)
    );

    // Stack-region memory model with access monitors
    logic [15:0] stk_mem [256];
    int          wr_cnt = 0, rd_cnt = 0, bad_addr = 0;
    logic [15:0] last_waddr = '0, last_wdata = '0, last_raddr = '0;

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_addr[15:8] != 8'hFF) bad_addr++;
            if (mem_we) begin
                stk_mem[mem_addr[7:0]] <= mem_wdata;
                last_waddr <= mem_addr;
                last_wdata <= mem_wdata;
                wr_cnt++;
            end else begin
                mem_rdata  <= stk_mem[mem_addr[7:0]];
                last_raddr <= mem_addr;
                rd_cnt++;
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req   = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Issue one instruction; returns edge count to done (12 means none)
    task automatic run_op(input logic [2:0] op, input logic [4:0] sel,
                          input logic [15:0] pc, input logic [3:0] len,
                          input logic [15:0] tgt,
                          output int lat, output logic [15:0] npc);
        @(negedge clk);
        opcode = op; cond_sel = sel; cur_pc = pc; ins_len = len; target = tgt;
        req = 1'b1;
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        req = 1'b0;
        while (!done && lat < 12) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        npc = next_pc;
    endtask

    task automatic t_reset();
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "halted", halted, 0);
        chk("R1", "stack_fault", stack_fault, 0);
        chk("R1", "opcode_fault", opcode_fault, 0);
        chk("R1", "depth", depth, 0);
    endtask

    task automatic t_plain_advance();
        int lat; logic [15:0] npc; int w0, r0;
        w0 = wr_cnt; r0 = rd_cnt;
        run_op(3'd0, 5'b1_0000, 16'h0100, 4'd2, 16'h4000, lat, npc);
        chk("R2", "continue next_pc", npc, 16'h0102);
        chk("R11", "continue latency", lat, 2);
        run_op(3'd1, 5'b1_0000, 16'hFFFE, 4'd3, 16'h4000, lat, npc);
        chk("R2", "false jump wraps", npc, 16'h0001);
        run_op(3'd2, 5'b1_0000, 16'h0200, 4'd4, 16'h4000, lat, npc);
        chk("R2", "false call next_pc", npc, 16'h0204);
        chk("R11", "false call latency", lat, 2);
        run_op(3'd3, 5'b1_0000, 16'h0300, 4'd1, 16'h4000, lat, npc);
        chk("R2", "false return next_pc", npc, 16'h0301);
        chk("R2", "no memory writes", wr_cnt - w0, 0);
        chk("R2", "no memory reads", rd_cnt - r0, 0);
        chk("R2", "depth kept", depth, 0);
    endtask

    task automatic t_conditions();
        int lat; logic [15:0] npc;
        err_flags = 4'b0100; sw_flags = 8'b0010_0000; ext_flag = 1'b0;
        run_op(3'd1, 5'd0, 16'h0010, 4'd1, 16'h0A00, lat, npc);
        chk("R4", "always jump", npc, 16'h0A00);
        chk("R11", "jump latency", lat, 2);
        run_op(3'd1, 5'd3, 16'h0010, 4'd1, 16'h0A01, lat, npc);
        chk("R3", "err bit2 set", npc, 16'h0A01);
        run_op(3'd1, 5'd2, 16'h0010, 4'd1, 16'h0A02, lat, npc);
        chk("R3", "err bit1 clear", npc, 16'h0011);
        run_op(3'd1, 5'd10, 16'h0010, 4'd1, 16'h0A03, lat, npc);
        chk("R3", "sw bit5 set", npc, 16'h0A03);
        run_op(3'd1, 5'd9, 16'h0010, 4'd1, 16'h0A04, lat, npc);
        chk("R3", "sw bit4 clear", npc, 16'h0011);
        run_op(3'd1, 5'd13, 16'h0010, 4'd1, 16'h0A05, lat, npc);
        chk("R3", "ext clear", npc, 16'h0011);
        run_op(3'd1, 5'b1_1101, 16'h0010, 4'd1, 16'h0A06, lat, npc);
        chk("R3", "inverted ext", npc, 16'h0A06);
        run_op(3'd1, 5'd14, 16'h0010, 4'd1, 16'h0A07, lat, npc);
        chk("R3", "index 14 false", npc, 16'h0011);
        run_op(3'd1, 5'b1_1111, 16'h0010, 4'd1, 16'h0A08, lat, npc);
        chk("R3", "inverted index 15", npc, 16'h0A08);
        // flags sampled at acceptance: change them during the instruction
        @(negedge clk);
        ext_flag = 1'b1;
        opcode = 3'd1; cond_sel = 5'd13; cur_pc = 16'h0020; ins_len = 4'd2;
        target = 16'h0B00; req = 1'b1;
        @(negedge clk);
        req = 1'b0; ext_flag = 1'b0;
        @(negedge clk);
        chk("R3", "ext sampled at accept", next_pc, 16'h0B00);
        err_flags = '0; sw_flags = '0;
    endtask

    task automatic t_call_return();
        int lat; logic [15:0] npc;
        logic [15:0] pcs [3] = '{16'h1000, 16'h2000, 16'h3000};
        for (int i = 0; i < 3; i++) begin
            run_op(3'd2, 5'd0, pcs[i], 4'd2, 16'h5000 + 16'(i), lat, npc);
            chk("R5", "call next_pc", npc, 16'h5000 + 16'(i));
            chk("R5", "write address", last_waddr, 16'hFFFF - 16'(i));
            chk("R5", "write data", last_wdata, pcs[i] + 16'd2);
            chk("R5", "depth after call", depth, 8'(i + 1));
            chk("R11", "call latency", lat, 3);
        end
        for (int i = 2; i >= 0; i--) begin
            run_op(3'd3, 5'd0, 16'h6000, 4'd1, 16'h0000, lat, npc);
            chk("R6", "return next_pc", npc, pcs[i] + 16'd2);
            chk("R6", "read address", last_raddr, 16'hFFFF - 16'(i));
            chk("R6", "depth after return", depth, 8'(i));
            chk("R11", "return latency", lat, 4);
        end
    endtask

    task automatic t_overflow();
        int lat; logic [15:0] npc; int w0, r0, oks;
        do_reset();
        oks = 0;
        for (int i = 0; i < 255; i++) begin
            run_op(3'd2, 5'd0, 16'(i), 4'd1, 16'h7000, lat, npc);
            if (lat == 3 && npc == 16'h7000) oks++;
        end
        chk("R7", "255 calls accepted", oks, 255);
        chk("R7", "depth full", depth, 8'd255);
        chk("R5", "deepest write address", last_waddr, 16'hFF01);
        w0 = wr_cnt;
        run_op(3'd2, 5'd0, 16'h0800, 4'd1, 16'h7000, lat, npc);
        chk("R7", "overflow gives no done", lat, 12);
        chk("R7", "halted", halted, 1);
        chk("R7", "stack_fault", stack_fault, 1);
        chk("R7", "opcode_fault", opcode_fault, 0);
        chk("R7", "no write", wr_cnt - w0, 0);
        chk("R7", "depth held", depth, 8'd255);
        w0 = wr_cnt; r0 = rd_cnt;
        run_op(3'd3, 5'd0, 16'h0900, 4'd1, 16'h0000, lat, npc);
        chk("R10", "return ignored, no done", lat, 12);
        chk("R10", "no access while halted", (wr_cnt - w0) + (rd_cnt - r0), 0);
        chk("R10", "depth frozen", depth, 8'd255);
        chk("R10", "still halted", halted, 1);
    endtask

    task automatic t_underflow();
        int lat; logic [15:0] npc; int r0;
        do_reset();
        r0 = rd_cnt;
        run_op(3'd3, 5'd0, 16'h0040, 4'd1, 16'h0000, lat, npc);
        chk("R8", "no done", lat, 12);
        chk("R8", "halted", halted, 1);
        chk("R8", "stack_fault", stack_fault, 1);
        chk("R8", "no read", rd_cnt - r0, 0);
        chk("R8", "depth zero", depth, 0);
    endtask

    task automatic t_illegal();
        int lat; logic [15:0] npc;
        do_reset();
        t_reset();
        run_op(3'd6, 5'b1_0000, 16'h0050, 4'd1, 16'h0000, lat, npc);
        chk("R9", "no done", lat, 12);
        chk("R9", "halted", halted, 1);
        chk("R9", "opcode_fault", opcode_fault, 1);
        chk("R9", "stack_fault clear", stack_fault, 0);
        do_reset();
        run_op(3'd4, 5'd0, 16'h0050, 4'd1, 16'h0000, lat, npc);
        chk("R9", "opcode 4 faults", opcode_fault, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R11 watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_plain_advance();
        t_conditions();
        t_call_return();
        t_overflow();
        t_underflow();
        t_illegal();
        chk("R5", "accesses outside stack region", bad_addr, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule